// File: doc/BRIEF.md
# Saturating Extended-Dividend Divider

This block performs the integer division step of a 32-bit divide instruction. It builds a 64-bit dividend by placing a 32-bit high-word register above the low word of the first operand. The divisor is either the low word of the second operand or a 13-bit immediate, sign-extended to 32 bits. The quotient comes from an iterative shift-and-subtract core that retires one quotient bit per clock. After that, the result is clamped into the 32-bit range of the selected mode and returned as a 64-bit value.

A caller pulses `start_i` while the block is idle, with the operands and mode present on the inputs in that cycle. The block raises `busy_o` for the duration of the division. When the result is ready it pulses `done_o` for one cycle, and `quot_o`, `ovf_o` and `dz_o` then hold their values until the next completion. A zero divisor is caught in the accept cycle: the block reports a fault at once and does not run the division. In the flag-setting form of the instruction, `ovf_o` feeds the overflow condition code.

Top module: `sat_xdiv`

## Requirements
- R1: The dividend is `{hiword_i, opa_i}` (high word in bits 63:32). The divisor is `opb_i` when `imm_sel_i`=0. When `imm_sel_i`=1 it is `imm_i` with bit 12 copied into bits 31:13, and this holds in both modes.
- R2: In unsigned mode (`signed_i`=0), a quotient below 2^32 appears zero-extended in `quot_o` with `ovf_o`=0.
- R3: In unsigned mode, a quotient of 2^32 or more gives `quot_o`=0x00000000FFFFFFFF and `ovf_o`=1.
- R4: In signed mode, both operands are read as two's complement. The quotient is truncated toward zero and appears sign-extended to 64 bits in `quot_o`.
- R5: In signed mode, a non-negative quotient above 0x7FFFFFFF gives `quot_o`=0x000000007FFFFFFF and `ovf_o`=1. This includes a dividend of -2^63 divided by -1.
- R6: In signed mode, a negative quotient below -2^31 gives `quot_o`=0xFFFFFFFF80000000 and `ovf_o`=1. A quotient of exactly -2^31 gives the same value with `ovf_o`=0.
- R7: A zero divisor raises `done_o` in the cycle right after the accepting edge, with `dz_o`=1, `quot_o`=0 and `ovf_o`=0. `busy_o` stays low. A non-zero divisor gives `dz_o`=0.
- R8: For a non-zero divisor, `busy_o` is high from the cycle after the accepting edge. `done_o` pulses for one cycle, 65 clock edges after the accepting edge, and `busy_o` is low while `done_o` is high.
- R9: A `start_i` pulse while `busy_o` is high is ignored. The running division completes with its own operands and on its own schedule.
- R10: After reset, `busy_o`, `done_o`, `ovf_o`, `dz_o` and `quot_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a division (taken only when idle) |
| signed_i | input | 1 | 1 = two's complement mode, 0 = unsigned |
| imm_sel_i | input | 1 | 1 = divisor from the immediate |
| hiword_i | input | 32 | Upper half of the dividend |
| opa_i | input | 32 | Low word of the first operand (lower half of dividend) |
| opb_i | input | 32 | Low word of the second operand |
| imm_i | input | 13 | Signed immediate divisor |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quot_o | output | 64 | Saturated quotient |
| ovf_o | output | 1 | Quotient was clamped |
| dz_o | output | 1 | Divide-by-zero fault |

## Verification
The bench targets the clamp boundaries directly:
- A signed quotient of exactly -2^31 must not raise overflow, and one step further must. A design that used the wrong comparison would flip the flag or the value at that point.
- A dividend of -2^63 divided by -1 has an unsigned magnitude of 2^63, which a sign-from-result design would misread as a negative underflow instead of a positive clamp.
- Negative immediates in unsigned mode must divide by 0xFFFFFFFF-range values. A zero-extending design would return large quotients there.
- Odd negative dividends check truncation toward zero against flooring.
- A zero divisor must give an immediate fault.
- A second start pulse, whose operands carry a zero divisor, is issued mid-run. A design that accepted it would report a fault or a changed quotient.

// File: rtl/sat_xdiv_pkg.sv
`timescale 1ns/1ps
package sat_xdiv_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIX  = 2'd2
   } xdiv_state_e;
endpackage

// File: rtl/xdiv_prep.sv
`timescale 1ns/1ps
module xdiv_prep #(
   parameter int WORD_W = 32,
   parameter int IMM_W  = 13,
   localparam int DVD_W = 2 * WORD_W
) (
   input  logic              signed_i,
   input  logic              imm_sel_i,
   input  logic [WORD_W-1:0] hiword_i,
   input  logic [WORD_W-1:0] opa_i,
   input  logic [WORD_W-1:0] opb_i,
   input  logic [IMM_W-1:0]  imm_i,
   output logic [DVD_W-1:0]  dvd_mag_o,
   output logic [WORD_W-1:0] dvs_mag_o,
   output logic              neg_o,
   output logic              zero_o
);
   logic [DVD_W-1:0]  dvd_raw;
   logic [WORD_W-1:0] dvs_raw;
   logic              dvd_neg, dvs_neg;

   // R1: extended dividend and divisor selection
   assign dvd_raw = {hiword_i, opa_i};
   assign dvs_raw = imm_sel_i ? {{(WORD_W-IMM_W){imm_i[IMM_W-1]}}, imm_i} : opb_i;

   assign dvd_neg = signed_i & dvd_raw[DVD_W-1];
   assign dvs_neg = signed_i & dvs_raw[WORD_W-1];

   assign dvd_mag_o = dvd_neg ? -dvd_raw : dvd_raw;
   assign dvs_mag_o = dvs_neg ? -dvs_raw : dvs_raw;
   assign neg_o     = dvd_neg ^ dvs_neg;
   assign zero_o    = (dvs_raw == '0);
endmodule

// File: rtl/xdiv_core.sv
`timescale 1ns/1ps
module xdiv_core #(
   parameter int DVD_W        = 64,
   parameter int DVS_W        = 32,
   parameter bit NONRESTORING = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             step_i,
   input  logic [DVD_W-1:0] dvd_i,
   input  logic [DVS_W-1:0] dvs_i,
   output logic [DVD_W-1:0] quo_o
);
   logic [DVD_W-1:0] quo_q;
   logic [DVS_W-1:0] dvs_q;
   logic             qbit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quo_q <= '0;
         dvs_q <= '0;
      end else if (load_i) begin
         quo_q <= dvd_i;
         dvs_q <= dvs_i;
      end else if (step_i) begin
         quo_q <= {quo_q[DVD_W-2:0], qbit};
      end
   end

   generate
      if (!NONRESTORING) begin : g_restoring
         logic [DVS_W-1:0] rem_q;
         logic [DVS_W:0]   shl, dif;
         assign shl  = {rem_q, quo_q[DVD_W-1]};
         assign dif  = shl - {1'b0, dvs_q};
         assign qbit = ~dif[DVS_W];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      rem_q <= '0;
            else if (load_i) rem_q <= '0;
            else if (step_i) rem_q <= dif[DVS_W] ? shl[DVS_W-1:0] : dif[DVS_W-1:0];
         end
         AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            step_i |-> (rem_q < dvs_q)); // R2
      end else begin : g_nonrestoring
         logic [DVS_W+1:0] rem_q, shl, nxt;
         assign shl  = {rem_q[DVS_W:0], quo_q[DVD_W-1]};
         assign nxt  = rem_q[DVS_W+1] ? shl + {2'b00, dvs_q} : shl - {2'b00, dvs_q};
         assign qbit = ~nxt[DVS_W+1];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      rem_q <= '0;
            else if (load_i) rem_q <= '0;
            else if (step_i) rem_q <= nxt;
         end
         AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            step_i |-> (($signed(rem_q) < $signed({2'b00, dvs_q})) &&
                        ($signed(rem_q) >= -$signed({2'b00, dvs_q})))); // R2
      end
   endgenerate

   assign quo_o = quo_q;
endmodule

// File: rtl/xdiv_sat.sv
`timescale 1ns/1ps
module xdiv_sat #(
   parameter int WORD_W = 32,
   localparam int DVD_W = 2 * WORD_W
) (
   input  logic             signed_i,
   input  logic             neg_i,
   input  logic [DVD_W-1:0] qmag_i,
   output logic [DVD_W-1:0] res_o,
   output logic             ovf_o
);
   logic [DVD_W-1:0] neg_lim;
   logic             u_ovf, p_ovf, n_ovf;

   assign neg_lim = DVD_W'(1) << (WORD_W-1);
   assign u_ovf   = |qmag_i[DVD_W-1:WORD_W];
   assign p_ovf   = |qmag_i[DVD_W-1:WORD_W-1];
   assign n_ovf   = qmag_i > neg_lim;

   always_comb begin
      if (!signed_i) begin                       // R2 R3
         ovf_o = u_ovf;
         res_o = u_ovf ? {{WORD_W{1'b0}}, {WORD_W{1'b1}}} : qmag_i;
      end else if (!neg_i) begin                 // R5
         ovf_o = p_ovf;
         res_o = p_ovf ? {{(WORD_W+1){1'b0}}, {(WORD_W-1){1'b1}}} : qmag_i;
      end else begin                             // R6
         ovf_o = n_ovf;
         res_o = n_ovf ? {{(WORD_W+1){1'b1}}, {(WORD_W-1){1'b0}}} : -qmag_i;
      end
   end
endmodule

// File: rtl/sat_xdiv.sv
`timescale 1ns/1ps
module sat_xdiv
   import sat_xdiv_pkg::*;
#(
   parameter int WORD_W       = 32,
   parameter int IMM_W        = 13,
   parameter bit NONRESTORING = 1'b0,
   localparam int DVD_W = 2 * WORD_W,
   localparam int CNT_W = $clog2(DVD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              signed_i,
   input  logic              imm_sel_i,
   input  logic [WORD_W-1:0] hiword_i,
   input  logic [WORD_W-1:0] opa_i,
   input  logic [WORD_W-1:0] opb_i,
   input  logic [IMM_W-1:0]  imm_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [DVD_W-1:0]  quot_o,
   output logic              ovf_o,
   output logic              dz_o
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DVD_W-1);

   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("sat_xdiv: WORD_W must be at least 2");
      end
      if (IMM_W < 1 || IMM_W > WORD_W) begin : g_bad_imm
         $error("sat_xdiv: IMM_W must lie in 1..WORD_W");
      end
   endgenerate

   xdiv_state_e       state;
   logic [CNT_W-1:0]  cnt;
   logic              sgn_q, neg_q;
   logic [DVD_W-1:0]  p_dvd, c_quo, s_res;
   logic [WORD_W-1:0] p_dvs;
   logic              p_neg, p_zero, s_ovf;
   logic              accept;

   assign accept = start_i && (state == ST_IDLE);   // R9
   assign busy_o = (state != ST_IDLE);

   xdiv_prep #(.WORD_W(WORD_W), .IMM_W(IMM_W)) u_prep (
      .signed_i (signed_i),
      .imm_sel_i(imm_sel_i),
      .hiword_i (hiword_i),
      .opa_i    (opa_i),
      .opb_i    (opb_i),
      .imm_i    (imm_i),
      .dvd_mag_o(p_dvd),
      .dvs_mag_o(p_dvs),
      .neg_o    (p_neg),
      .zero_o   (p_zero)
   );

   xdiv_core #(.DVD_W(DVD_W), .DVS_W(WORD_W), .NONRESTORING(NONRESTORING)) u_core (
      .clk   (clk),
      .rst_n (rst_n),
      .load_i(accept && !p_zero),
      .step_i(state == ST_RUN),
      .dvd_i (p_dvd),
      .dvs_i (p_dvs),
      .quo_o (c_quo)
   );

   xdiv_sat #(.WORD_W(WORD_W)) u_sat (
      .signed_i(sgn_q),
      .neg_i   (neg_q),
      .qmag_i  (c_quo),
      .res_o   (s_res),
      .ovf_o   (s_ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         sgn_q  <= 1'b0;
         neg_q  <= 1'b0;
         done_o <= 1'b0;
         quot_o <= '0;
         ovf_o  <= 1'b0;
         dz_o   <= 1'b0;
      end else begin
         done_o <= 1'b0;
         case (state)
            ST_IDLE: if (accept) begin
               sgn_q <= signed_i;
               neg_q <= p_neg;
               cnt   <= '0;
               if (p_zero) begin                 // R7
                  done_o <= 1'b1;
                  dz_o   <= 1'b1;
                  ovf_o  <= 1'b0;
                  quot_o <= '0;
               end else begin
                  state <= ST_RUN;
               end
            end
            ST_RUN: begin                        // R8
               if (cnt == LAST) state <= ST_FIX;
               else             cnt   <= cnt + 1'b1;
            end
            ST_FIX: begin
               quot_o <= s_res;
               ovf_o  <= s_ovf;
               dz_o   <= 1'b0;
               done_o <= 1'b1;
               state  <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !done_o); // R8
   AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dz_o) |-> done_o); // R7
   AST_UNS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !sgn_q) |-> (quot_o[DVD_W-1:WORD_W] == '0)); // R2
   AST_UNS_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !sgn_q && ovf_o) |-> (quot_o == {{WORD_W{1'b0}}, {WORD_W{1'b1}}})); // R3
   AST_SGN_EXTENDED: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && sgn_q && !dz_o) |->
         (($countones(quot_o[DVD_W-1:WORD_W-1]) == 0) ||
          ($countones(quot_o[DVD_W-1:WORD_W-1]) == WORD_W+1))); // R4
endmodule

// File: tb/sim_sat_xdiv.sv
`timescale 1ns/1ps
module sim_sat_xdiv;
   localparam int LAT = 65;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0, signed_i = 1'b0, imm_sel_i = 1'b0;
   logic [31:0] hiword_i = '0, opa_i = '0, opb_i = '0;
   logic [12:0] imm_i = '0;
   logic        busy_o, done_o, ovf_o, dz_o;
   logic [63:0] quot_o;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   sat_xdiv u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
      .imm_sel_i(imm_sel_i), .hiword_i(hiword_i), .opa_i(opa_i), .opb_i(opb_i),
      .imm_i(imm_i), .busy_o(busy_o), .done_o(done_o), .quot_o(quot_o),
      .ovf_o(ovf_o), .dz_o(dz_o)
   );

   task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Expected result from the requirements (R1..R7)
   task automatic model(input logic s, input logic ui, input logic [31:0] hi,
                        input logic [31:0] a, input logic [31:0] b, input logic [12:0] imm,
                        output logic [63:0] res, output logic ovf, output logic dz);
      logic [63:0] dvd, dm, q;
      logic [31:0] dv, vm;
      logic        ng;
      dvd = {hi, a};
      dv  = ui ? {{19{imm[12]}}, imm} : b;           // R1
      dz  = (dv == 32'd0);
      res = '0; ovf = 1'b0;
      if (!dz) begin
         if (!s) begin
            q = dvd / {32'd0, dv};
            if (q[63:32] != 0) begin res = 64'h00000000FFFFFFFF; ovf = 1'b1; end   // R3
            else res = q;                                                       // R2
         end else begin
            dm = dvd[63] ? -dvd : dvd;
            vm = dv[31] ? -dv : dv;
            q  = dm / {32'd0, vm};
            ng = dvd[63] ^ dv[31];
            if (!ng) begin
               if (q > 64'h7FFFFFFF) begin res = 64'h000000007FFFFFFF; ovf = 1'b1; end // R5
               else res = q;
            end else begin
               if (q > 64'h80000000) begin res = 64'hFFFFFFFF80000000; ovf = 1'b1; end // R6
               else res = -q;                                                        // R4
            end
         end
      end
   endtask

   task automatic run(input string tag, input logic s, input logic ui, input logic [31:0] hi,
                      input logic [31:0] a, input logic [31:0] b, input logic [12:0] imm,
                      input int inject_at);
      logic [63:0] er;
      logic eo, ez;
      int n;
      model(s, ui, hi, a, b, imm, er, eo, ez);
      @(negedge clk);
      start_i = 1'b1; signed_i = s; imm_sel_i = ui;
      hiword_i = hi; opa_i = a; opb_i = b; imm_i = imm;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      if (!ez) begin
         checks++;
         if (busy_o !== 1'b1) begin fails++; $display("FAIL R8 %s busy actual=%b expected=1", tag, busy_o); end
      end
      n = 0;
      while (!done_o && n < 300) begin
         if (n == inject_at) begin          // R9: mid-run request with other operands
            start_i = 1'b1; signed_i = ~s; imm_sel_i = 1'b0;
            hiword_i = 32'h1234_5678; opa_i = 32'h9; opb_i = 32'h0;
         end else begin
            start_i = 1'b0;
         end
         @(posedge clk);
         @(negedge clk);
         n++;
      end
      start_i = 1'b0;
      check64({tag, " result R2-R6"}, quot_o, er);
      check64({tag, " ovf"}, {63'd0, ovf_o}, {63'd0, eo});
      check64({tag, " dz R7"}, {63'd0, dz_o}, {63'd0, ez});
      check64({tag, " latency R8"}, 64'(n), ez ? 64'd0 : 64'(LAT));
      check64({tag, " busy at done R8"}, {63'd0, busy_o}, 64'd0);
      @(negedge clk);
      check64({tag, " done pulse R8"}, {63'd0, done_o}, 64'd0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL R8 watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R10 reset state
      check64("R10 reset busy/done/ovf/dz", {60'd0, busy_o, done_o, ovf_o, dz_o}, 64'd0);
      check64("R10 reset quot", quot_o, 64'd0);
      rst_n = 1'b1;

      run("R2 unsigned small", 1'b0, 1'b0, 32'd0, 32'd1000, 32'd7, 13'd0, -1);
      run("R2 unsigned hi word", 1'b0, 1'b0, 32'd3, 32'h0000_0010, 32'h0000_0004, 13'd0, -1);
      run("R3 unsigned clamp", 1'b0, 1'b0, 32'h0000_0010, 32'd0, 32'd2, 13'd0, -1);
      run("R1 unsigned neg imm", 1'b0, 1'b1, 32'h0000_0001, 32'h0000_0000, 32'd5, 13'h1FFF, -1);
      run("R1 signed imm", 1'b1, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FF9C, 32'd0, 13'h1FFB, -1);
      run("R4 trunc toward zero", 1'b1, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFF9, 32'd2, 13'd0, -1);
      run("R4 neg divisor", 1'b1, 1'b0, 32'd0, 32'd7, 32'hFFFF_FFFE, 13'd0, -1);
      run("R5 signed pos clamp", 1'b1, 1'b0, 32'h0000_0001, 32'd0, 32'd1, 13'd0, -1);
      run("R5 min div minus one", 1'b1, 1'b0, 32'h8000_0000, 32'd0, 32'hFFFF_FFFF, 13'd0, -1);
      run("R6 exact min no ovf", 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h8000_0000, 32'd1, 13'd0, -1);
      run("R6 below min clamp", 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'd1, 13'd0, -1);
      run("R7 zero reg divisor", 1'b0, 1'b0, 32'd5, 32'd5, 32'd0, 13'd0, -1);
      run("R7 zero imm divisor", 1'b1, 1'b1, 32'd5, 32'd5, 32'hFFFF, 13'd0, -1);
      run("R9 start while busy", 1'b0, 1'b0, 32'd0, 32'd99, 32'd4, 13'd0, 10);

      for (int i = 0; i < 60; i++) begin
         logic s, ui;
         logic [31:0] hi, a, b;
         logic [12:0] imm;
         s   = 1'($urandom % 2);
         ui  = (($urandom % 4) == 0);
         a   = $urandom;
         b   = (($urandom % 3) == 0) ? ($urandom % 64) : $urandom;
         imm = 13'($urandom);
         case ($urandom % 3)
            0: hi = 32'd0;
            1: hi = {32{a[31]}};
            default: hi = $urandom;
         endcase
         run("random", s, ui, hi, a, b, imm, -1);
      end

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule